// File: doc/BRIEF.md
# Shared-Pool Multi-Queue Block Manager

This block keeps several FIFO packet queues inside one common pool of fixed 64-byte data blocks. Each queue is a singly linked chain of block addresses. A small per-queue table holds the head, the tail and the length of every chain. A separate on-chip pointer store holds, for each block, the link to the following block and a 5-bit descriptor. Blocks not owned by any queue sit on a free chain. The block deals in addresses only. Payload storage, any external memory controller and the choice of which queue to serve all belong to other blocks.

The 5-bit descriptor is `{eop, words_m1}`. `words_m1` is the number of occupied 4-byte words minus one, so a block can report from 4 to 64 bytes. `eop` marks the final block of a packet. A full block appears twice, with `eop` clear for a block in the middle of a packet and with `eop` set for the end of a packet whose length is a multiple of 64. The reader of a queue therefore learns where packets end and how long their tails are without fetching any payload.

A client presents a single enqueue or dequeue while `busy` is low. An accepted operation does one read of the pointer store. The read returns one cycle later, one more cycle is lost before the returned pointer can be used, and a final cycle does the write-back. Refused operations answer on the next cycle and change nothing.

Top module: `mq_block_mgr`

## Requirements
- R1: After reset every queue is empty and all 2**PTR_W blocks are free. The first allocations after reset hand out block addresses 0, 1, 2, … in increasing order.
- R2: An enqueue descriptor with `enq_last`=0 and `enq_cnt` not equal to 15 is illegal. It is refused with `rsp_valid`=1, `rsp_ok`=0 and `rsp_err`=1 on the next cycle, `busy` stays low, and no queue or free-list state changes.
- R3: A legal enqueue with at least one free block is accepted. `busy` is high for the three cycles after acceptance and `rsp_valid` stays low during them. On the following cycle `rsp_valid`=1, `rsp_ok`=1, `rsp_err`=0, and `rsp_addr` gives the block that was allocated.
- R4: Dequeues of a queue return its blocks in the order they were enqueued. Each returned block carries the `{last, cnt}` that was stored with it. A dequeue has the same three-cycle busy window as an enqueue.
- R5: With every successful response, `rsp_bytes` equals 4·(`rsp_cnt`+1) and `rsp_last` marks the end of a packet. A full block has `rsp_cnt`=15 and either `rsp_last` value.
- R6: A dequeue from an empty queue is refused with `rsp_valid`=1, `rsp_ok`=0 and `rsp_err`=0 on the next cycle, with `busy` low.
- R7: A legal enqueue when no block is free is refused with `rsp_ok`=0 and `rsp_err`=0 and changes no state. The total of all queue lengths plus the free count always equals 2**PTR_W.
- R8: The free list is last-in first-out. The block most recently released by a dequeue is the next block handed to an enqueue.
- R9: Requests presented while `busy` is high are ignored. Each operation produces exactly one `rsp_valid` pulse, and `busy` falls only together with a successful response.
- R10: When `enq_req` and `deq_req` are both high in an idle cycle, only the enqueue is performed and the dequeue is dropped.
- R11: Queues are independent. Operations on one queue never change the contents or the order of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_req | input | 1 | Enqueue request, sampled while not busy |
| enq_qid | input | QID_W | Target queue of the enqueue |
| enq_last | input | 1 | Block ends its packet |
| enq_cnt | input | 4 | Occupied 4-byte words minus one |
| deq_req | input | 1 | Dequeue request, sampled while not busy |
| deq_qid | input | QID_W | Queue to dequeue from |
| busy | output | 1 | Operation in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Operation performed |
| rsp_err | output | 1 | Refused because of an illegal descriptor |
| rsp_addr | output | PTR_W | Block allocated or released |
| rsp_last | output | 1 | End-of-packet flag of that block |
| rsp_cnt | output | 4 | Word count minus one of that block |
| rsp_bytes | output | 7 | Occupied bytes of that block |

## Verification
A broken link or a lost block shows up late. A wrong tail pointer is only seen when the chain is walked, which is the dequeue that follows the damaged link and may come many operations after the fault. A corrupted free chain appears at the next allocation as an unexpected `rsp_addr`. A miscounted queue length appears as a wrong refusal or acceptance. For this reason a behavioural model predicts every response and the busy window on each clock. The stimulus walks every queue to empty and drains the pool completely, so a damaged link cannot stay hidden.

// File: rtl/mqm_pkg.sv
package mqm_pkg;
   localparam int unsigned WORDS_W = 4;
   localparam logic [WORDS_W-1:0] FULL_WORDS = 4'd15;

   typedef struct packed {
      logic                eop;
      logic [WORDS_W-1:0]  words_m1;
   } blk_desc_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENQ_RD,
      ST_ENQ_GAP,
      ST_ENQ_WR,
      ST_DEQ_RD,
      ST_DEQ_GAP,
      ST_DEQ_WR
   } mgr_state_e;
endpackage

// File: rtl/mqm_ptr_mem.sv
module mqm_ptr_mem
   import mqm_pkg::*;
#(
   parameter int unsigned PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] rd_addr,
   input  logic             link_we,
   input  logic [PTR_W-1:0] link_waddr,
   input  logic [PTR_W-1:0] link_wdata,
   input  logic             desc_we,
   input  logic [PTR_W-1:0] desc_waddr,
   input  blk_desc_t        desc_wdata,
   output logic [PTR_W-1:0] rd_link,
   output blk_desc_t        rd_desc
);
   localparam int unsigned DEPTH = 1 << PTR_W;

   logic [PTR_W-1:0] link_arr [DEPTH];
   blk_desc_t        desc_arr [DEPTH];
   logic [PTR_W-1:0] addr_q;

   // reset links every block to its successor: the initial free chain
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            link_arr[i] <= PTR_W'(i + 1);
            desc_arr[i] <= '0;
         end
      end else begin
         if (rd_en)   addr_q               <= rd_addr;
         if (link_we) link_arr[link_waddr] <= link_wdata;
         if (desc_we) desc_arr[desc_waddr] <= desc_wdata;
      end
   end

   // fall-through read: data follows the registered address combinationally
   assign rd_link = link_arr[addr_q];
   assign rd_desc = desc_arr[addr_q];

   // R2
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> (desc_wdata.eop || desc_wdata.words_m1 == FULL_WORDS));
endmodule

// File: rtl/mqm_qtable.sv
module mqm_qtable #(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned PTR_W = 4,
   parameter int unsigned LEN_W = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [$clog2(NUM_Q)-1:0]        sel,
   input  logic                            head_we,
   input  logic [PTR_W-1:0]                head_d,
   input  logic                            tail_we,
   input  logic [PTR_W-1:0]                tail_d,
   input  logic                            len_inc,
   input  logic                            len_dec,
   output logic [PTR_W-1:0]                head_o,
   output logic [PTR_W-1:0]                tail_o,
   output logic [LEN_W-1:0]                len_o,
   output logic [NUM_Q-1:0][LEN_W-1:0]     len_all
);
   localparam int unsigned QID_W = $clog2(NUM_Q);
   localparam int unsigned POOL  = 1 << PTR_W;

   logic [NUM_Q-1:0][PTR_W-1:0] head_r;
   logic [NUM_Q-1:0][PTR_W-1:0] tail_r;

   for (genvar g = 0; g < NUM_Q; g++) begin : g_q
      logic hit;
      assign hit = (sel == QID_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            head_r[g]  <= '0;
            tail_r[g]  <= '0;
            len_all[g] <= '0;
         end else if (hit) begin
            if (head_we) head_r[g] <= head_d;
            if (tail_we) tail_r[g] <= tail_d;
            if (len_inc)      len_all[g] <= len_all[g] + LEN_W'(1);
            else if (len_dec) len_all[g] <= len_all[g] - LEN_W'(1);
         end
      end

      // R7
      len_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
         int'(len_all[g]) <= int'(POOL));
   end

   assign head_o = head_r[sel];
   assign tail_o = tail_r[sel];
   assign len_o  = len_all[sel];

   // R11
   one_len_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(len_inc && len_dec));
endmodule

// File: rtl/mqm_ctrl.sv
module mqm_ctrl
   import mqm_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned PTR_W = 4,
   parameter int unsigned LEN_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enq_req,
   input  logic [$clog2(NUM_Q)-1:0] enq_qid,
   input  blk_desc_t                enq_desc,
   input  logic                     deq_req,
   input  logic [$clog2(NUM_Q)-1:0] deq_qid,
   output logic [$clog2(NUM_Q)-1:0] qt_sel,
   output logic                     qt_head_we,
   output logic [PTR_W-1:0]         qt_head_d,
   output logic                     qt_tail_we,
   output logic [PTR_W-1:0]         qt_tail_d,
   output logic                     qt_len_inc,
   output logic                     qt_len_dec,
   input  logic [PTR_W-1:0]         q_head,
   input  logic [PTR_W-1:0]         q_tail,
   input  logic [LEN_W-1:0]         q_len,
   output logic                     mem_rd_en,
   output logic [PTR_W-1:0]         mem_rd_addr,
   output logic                     mem_link_we,
   output logic [PTR_W-1:0]         mem_link_waddr,
   output logic [PTR_W-1:0]         mem_link_wdata,
   output logic                     mem_desc_we,
   output logic [PTR_W-1:0]         mem_desc_waddr,
   output blk_desc_t                mem_desc_wdata,
   input  logic [PTR_W-1:0]         mem_link,
   input  blk_desc_t                mem_desc,
   output logic                     busy,
   output logic                     rsp_valid,
   output logic                     rsp_ok,
   output logic                     rsp_err,
   output logic [PTR_W-1:0]         rsp_addr,
   output blk_desc_t                rsp_desc,
   output logic [LEN_W-1:0]         free_cnt
);
   localparam int unsigned QID_W = $clog2(NUM_Q);
   localparam int unsigned POOL  = 1 << PTR_W;

   mgr_state_e       st;
   logic [QID_W-1:0] op_q;
   blk_desc_t        op_desc;
   logic [PTR_W-1:0] blk;
   logic [PTR_W-1:0] link_hold;
   logic [PTR_W-1:0] free_head;
   logic             idle;
   logic             code_bad;
   logic             enq_take;
   logic             deq_take;

   assign idle     = (st == ST_IDLE);
   assign busy     = !idle;
   assign code_bad = !enq_desc.eop && (enq_desc.words_m1 != FULL_WORDS);
   assign enq_take = idle && enq_req && !code_bad && (free_cnt != '0);
   assign deq_take = idle && !enq_req && deq_req && (q_len != '0);

   always_comb begin
      qt_sel         = idle ? (enq_req ? enq_qid : deq_qid) : op_q;
      mem_rd_en      = enq_take || deq_take;
      mem_rd_addr    = enq_req ? free_head : q_head;
      qt_head_we     = 1'b0;
      qt_head_d      = blk;
      qt_tail_we     = 1'b0;
      qt_tail_d      = blk;
      qt_len_inc     = 1'b0;
      qt_len_dec     = 1'b0;
      mem_link_we    = 1'b0;
      mem_link_waddr = blk;
      mem_link_wdata = free_head;
      mem_desc_we    = 1'b0;
      mem_desc_waddr = blk;
      mem_desc_wdata = op_desc;
      case (st)
         ST_ENQ_WR: begin
            mem_desc_we    = 1'b1;
            mem_link_we    = (q_len != '0);
            mem_link_waddr = q_tail;
            mem_link_wdata = blk;
            qt_tail_we     = 1'b1;
            qt_head_we     = (q_len == '0);
            qt_len_inc     = 1'b1;
         end
         ST_DEQ_WR: begin
            mem_link_we    = 1'b1;
            qt_head_we     = 1'b1;
            qt_head_d      = link_hold;
            qt_len_dec     = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         op_q      <= '0;
         op_desc   <= '0;
         blk       <= '0;
         link_hold <= '0;
         free_head <= '0;
         free_cnt  <= LEN_W'(POOL);
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
         rsp_desc  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (enq_req) begin
                  if (enq_take) begin
                     op_q    <= enq_qid;
                     op_desc <= enq_desc;
                     blk     <= free_head;
                     st      <= ST_ENQ_RD;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_ok    <= 1'b0;
                     rsp_err   <= code_bad;
                  end
               end else if (deq_req) begin
                  if (deq_take) begin
                     op_q <= deq_qid;
                     blk  <= q_head;
                     st   <= ST_DEQ_RD;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_ok    <= 1'b0;
                     rsp_err   <= 1'b0;
                  end
               end
            end
            ST_ENQ_RD: begin
               link_hold <= mem_link;
               st        <= ST_ENQ_GAP;
            end
            ST_ENQ_GAP: st <= ST_ENQ_WR;
            ST_ENQ_WR: begin
               free_head <= link_hold;
               free_cnt  <= free_cnt - LEN_W'(1);
               rsp_valid <= 1'b1;
               rsp_ok    <= 1'b1;
               rsp_err   <= 1'b0;
               rsp_addr  <= blk;
               rsp_desc  <= op_desc;
               st        <= ST_IDLE;
            end
            ST_DEQ_RD: begin
               link_hold <= mem_link;
               op_desc   <= mem_desc;
               st        <= ST_DEQ_GAP;
            end
            ST_DEQ_GAP: st <= ST_DEQ_WR;
            ST_DEQ_WR: begin
               free_head <= blk;
               free_cnt  <= free_cnt + LEN_W'(1);
               rsp_valid <= 1'b1;
               rsp_ok    <= 1'b1;
               rsp_err   <= 1'b0;
               rsp_addr  <= blk;
               rsp_desc  <= op_desc;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (rsp_valid && rsp_ok));
endmodule

// File: rtl/mq_block_mgr.sv
module mq_block_mgr
   import mqm_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned PTR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enq_req,
   input  logic [$clog2(NUM_Q)-1:0] enq_qid,
   input  logic                     enq_last,
   input  logic [3:0]               enq_cnt,
   input  logic                     deq_req,
   input  logic [$clog2(NUM_Q)-1:0] deq_qid,
   output logic                     busy,
   output logic                     rsp_valid,
   output logic                     rsp_ok,
   output logic                     rsp_err,
   output logic [PTR_W-1:0]         rsp_addr,
   output logic                     rsp_last,
   output logic [3:0]               rsp_cnt,
   output logic [6:0]               rsp_bytes
);
   localparam int unsigned QID_W = $clog2(NUM_Q);
   localparam int unsigned LEN_W = PTR_W + 1;
   localparam int unsigned POOL  = 1 << PTR_W;

   if (PTR_W < 2 || PTR_W > 24) begin : g_bad_ptr_w
      $error("mq_block_mgr: PTR_W must lie in 2..24");
   end
   if (NUM_Q < 2 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_bad_num_q
      $error("mq_block_mgr: NUM_Q must be a power of two, at least 2");
   end

   blk_desc_t                 enq_desc;
   blk_desc_t                 rsp_desc;
   logic [QID_W-1:0]          qt_sel;
   logic                      qt_head_we, qt_tail_we, qt_len_inc, qt_len_dec;
   logic [PTR_W-1:0]          qt_head_d, qt_tail_d, q_head, q_tail;
   logic [LEN_W-1:0]          q_len, free_cnt;
   logic [NUM_Q-1:0][LEN_W-1:0] len_all;
   logic                      mem_rd_en, mem_link_we, mem_desc_we;
   logic [PTR_W-1:0]          mem_rd_addr, mem_link_waddr, mem_link_wdata;
   logic [PTR_W-1:0]          mem_desc_waddr, mem_link;
   blk_desc_t                 mem_desc_wdata, mem_desc;

   assign enq_desc = '{eop: enq_last, words_m1: enq_cnt};

   mqm_ctrl #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .enq_req(enq_req), .enq_qid(enq_qid), .enq_desc(enq_desc),
      .deq_req(deq_req), .deq_qid(deq_qid),
      .qt_sel(qt_sel), .qt_head_we(qt_head_we), .qt_head_d(qt_head_d),
      .qt_tail_we(qt_tail_we), .qt_tail_d(qt_tail_d),
      .qt_len_inc(qt_len_inc), .qt_len_dec(qt_len_dec),
      .q_head(q_head), .q_tail(q_tail), .q_len(q_len),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_link_we(mem_link_we), .mem_link_waddr(mem_link_waddr),
      .mem_link_wdata(mem_link_wdata),
      .mem_desc_we(mem_desc_we), .mem_desc_waddr(mem_desc_waddr),
      .mem_desc_wdata(mem_desc_wdata),
      .mem_link(mem_link), .mem_desc(mem_desc),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
      .rsp_addr(rsp_addr), .rsp_desc(rsp_desc), .free_cnt(free_cnt)
   );

   mqm_qtable #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_qtable (
      .clk(clk), .rst_n(rst_n), .sel(qt_sel),
      .head_we(qt_head_we), .head_d(qt_head_d),
      .tail_we(qt_tail_we), .tail_d(qt_tail_d),
      .len_inc(qt_len_inc), .len_dec(qt_len_dec),
      .head_o(q_head), .tail_o(q_tail), .len_o(q_len), .len_all(len_all)
   );

   mqm_ptr_mem #(.PTR_W(PTR_W)) u_ptr_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
      .link_we(mem_link_we), .link_waddr(mem_link_waddr), .link_wdata(mem_link_wdata),
      .desc_we(mem_desc_we), .desc_waddr(mem_desc_waddr), .desc_wdata(mem_desc_wdata),
      .rd_link(mem_link), .rd_desc(mem_desc)
   );

   assign rsp_last  = rsp_desc.eop;
   assign rsp_cnt   = rsp_desc.words_m1;
   assign rsp_bytes = {({1'b0, rsp_desc.words_m1} + 5'd1), 2'b00};

   int unsigned pool_sum;
   always_comb begin
      pool_sum = int'(free_cnt);
      for (int q = 0; q < int'(NUM_Q); q++) pool_sum += int'(len_all[q]);
   end

   // R7
   pool_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pool_sum == POOL);

   // R2
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && enq_req && !enq_last && enq_cnt != 4'd15)
      |=> (rsp_valid && rsp_err && !rsp_ok && !busy));

   // R6
   refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok) |-> !busy);
endmodule

// File: tb/mq_block_mgr_tb.sv
module mq_block_mgr_tb_top;
   localparam int NQ   = 4;
   localparam int PW   = 4;
   localparam int POOL = 1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enq_req = 1'b0;
   logic [1:0]    enq_qid = '0;
   logic          enq_last = 1'b0;
   logic [3:0]    enq_cnt = '0;
   logic          deq_req = 1'b0;
   logic [1:0]    deq_qid = '0;
   logic          busy, rsp_valid, rsp_ok, rsp_err, rsp_last;
   logic [PW-1:0] rsp_addr;
   logic [3:0]    rsp_cnt;
   logic [6:0]    rsp_bytes;

   int n_chk = 0;
   int n_err = 0;
   int free_m[$];
   int q_m[NQ][$];

   always #5 clk = ~clk;

   mq_block_mgr #(.NUM_Q(NQ), .PTR_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .enq_req(enq_req), .enq_qid(enq_qid), .enq_last(enq_last), .enq_cnt(enq_cnt),
      .deq_req(deq_req), .deq_qid(deq_qid),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
      .rsp_addr(rsp_addr), .rsp_last(rsp_last), .rsp_cnt(rsp_cnt), .rsp_bytes(rsp_bytes)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one operation; model predicts the answer, bench checks every cycle
   task automatic run_op(input bit is_enq, input int q, input bit last, input int cnt,
                         input bit poke, input bit both);
      bit acc = 1'b0;
      bit e_err = 1'b0;
      int e_addr = 0;
      int e_last = 0;
      int e_cnt = 0;
      string rq;
      if (is_enq) begin
         rq = "R3";
         if (!last && cnt != 15) begin
            e_err = 1'b1; rq = "R2";
         end else if (free_m.size() == 0) begin
            rq = "R7";
         end else begin
            acc = 1'b1;
            e_addr = free_m.pop_front();
            e_last = last; e_cnt = cnt;
            q_m[q].push_back(e_addr * 32 + int'(last) * 16 + cnt);
         end
      end else begin
         rq = "R4";
         if (q_m[q].size() == 0) begin
            rq = "R6";
         end else begin
            int v;
            acc = 1'b1;
            v = q_m[q].pop_front();
            e_addr = v / 32; e_last = (v / 16) % 2; e_cnt = v % 16;
            free_m.push_front(e_addr);
         end
      end
      @(negedge clk);
      enq_req  = is_enq;
      enq_qid  = 2'(q);
      enq_last = last;
      enq_cnt  = 4'(cnt);
      deq_req  = !is_enq || both;
      deq_qid  = both ? 2'((q + 1) % NQ) : 2'(q);
      @(negedge clk);
      enq_req = 1'b0;
      deq_req = 1'b0;
      if (acc) begin
         for (int k = 0; k < 3; k++) begin
            chk(rq, "busy in window", int'(busy), 1);
            chk(rq, "rsp_valid in window", int'(rsp_valid), 0);
            if (poke && k == 0) begin
               deq_req = 1'b1;   // R9: must be ignored while busy
               deq_qid = 2'(q);
            end
            @(negedge clk);
            deq_req = 1'b0;
         end
         chk(rq, "rsp_valid", int'(rsp_valid), 1);
         chk(rq, "rsp_ok", int'(rsp_ok), 1);
         chk(rq, "rsp_err", int'(rsp_err), 0);
         chk(rq, "rsp_addr", int'(rsp_addr), e_addr);
         chk("R5", "rsp_last", int'(rsp_last), e_last);
         chk("R5", "rsp_cnt", int'(rsp_cnt), e_cnt);
         chk("R5", "rsp_bytes", int'(rsp_bytes), 4 * (e_cnt + 1));
      end else begin
         chk(rq, "refused busy", int'(busy), 0);
         chk(rq, "refused rsp_valid", int'(rsp_valid), 1);
         chk(rq, "refused rsp_ok", int'(rsp_ok), 0);
         chk(rq, "refused rsp_err", int'(rsp_err), int'(e_err));
      end
      @(negedge clk);
      chk("R9", "single pulse rsp_valid", int'(rsp_valid), 0);
      chk("R9", "no hidden op busy", int'(busy), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < POOL; i++) free_m.push_back(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset busy", int'(busy), 0);
      chk("R1", "reset rsp_valid", int'(rsp_valid), 0);

      // R1 R3 R4: a three-block packet on queue 0, addresses 0,1,2
      run_op(1, 0, 0, 15, 0, 0);
      run_op(1, 0, 0, 15, 0, 0);
      run_op(1, 0, 1, 2, 0, 0);
      // R5 full block ending a packet, queue 1
      run_op(1, 1, 1, 15, 0, 0);
      // R2 illegal codes
      run_op(1, 2, 0, 3, 0, 0);
      run_op(1, 2, 0, 0, 0, 0);
      // R6 empty dequeue
      run_op(0, 2, 0, 0, 0, 0);
      // R4 R11 drain queue 0 in order
      run_op(0, 0, 0, 0, 0, 0);
      run_op(0, 0, 0, 0, 0, 0);
      run_op(0, 0, 0, 0, 0, 0);
      run_op(0, 0, 0, 0, 0, 0);
      // R8 last freed block (2) is reused first
      run_op(1, 3, 1, 0, 0, 0);
      // R9 request while busy ignored
      run_op(1, 3, 0, 15, 1, 0);
      run_op(0, 1, 0, 0, 1, 0);
      // R10 both requests: only enqueue
      run_op(1, 1, 1, 7, 0, 1);
      // R7 exhaust the pool on queue 2, then one refused
      while (free_m.size() > 0) run_op(1, 2, 1, 7, 0, 0);
      run_op(1, 2, 1, 7, 0, 0);
      // R4 R11 drain everything, then empties refused
      for (int q = 0; q < NQ; q++) begin
         while (q_m[q].size() > 0) run_op(0, q, 0, 0, 0, 0);
         run_op(0, q, 0, 0, 0, 0);
      end
      // R8 after a full drain
      run_op(1, 0, 1, 11, 0, 0);
      run_op(0, 0, 0, 0, 0, 0);
      run_op(1, 1, 0, 15, 0, 0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule